// File: doc/BRIEF.md
# Stack-Operation Microprogram Sequencer

This block steps a 16-bit processor through the short microprograms behind its stack-style instructions: near call, near return, store-string and register push. The instruction decoder hands it a 5-bit entry microaddress. From then on the sequencer walks an internal control-word ROM, one word per enabled execution step. Each word drives the following fields:

- the two register-file read addresses;
- the ALU operand selects, operation and flag control;
- the memory input mode;
- the result destination;
- the kind of the next step.

A microaddress of zero means idle. A word whose next-address field is zero hands control back to instruction fetch.

A control word can tell the sequencer to keep the decoder's read address on either port instead of its own. It can also force the operand-width flag to a fixed value. This lets one shared microsequence serve any register or any width. The push sequence relies on this: the decoder picks the register, and the microprogram only supplies the stack-pointer arithmetic and the memory write. The sequencer stays on its current word while the execution stage has not granted a step, or while a memory access is still outstanding.

Top module: `stack_useq`

## Requirements
- R1: `rst` is synchronous and active high. At the edge that samples `rst` high, `uaddr` becomes 0 and `busy` becomes 0. This holds even in the middle of a sequence.
- R2: While idle (`uaddr` is 0), `entry_valid` = 1 loads `entry_addr` into `uaddr` at the next edge, and `busy` becomes 1. An entry address of 0 leaves the sequencer idle.
- R3: While busy, `entry_valid` and `entry_addr` are ignored.
- R4: While busy, `uaddr` moves to the low five bits of the current word's next-address field only at an edge where `step_en` = 1 and `mem_pending` = 0. At any other edge it holds. While idle, `step_en` has no effect.
- R5: A next-address field of 0 returns the sequencer to idle (`busy` = 0). Unpopulated microaddresses 10 to 31 read as an all-zero word, so a sequence entered there ends on its first step.
- R6: Word bit 33 set makes `rd1_addr` equal `dec_rd1_addr`, and word bit 34 set makes `rd2_addr` equal `dec_rd2_addr`. When the bit is clear, the word's own address field drives the port. Only words 8 and 9 set bit 34. No word sets bit 33.
- R7: Word bit 36 set forces `wide` to word bit 35. When bit 36 is clear, `wide` follows `dec_wide`. Only word 7 sets bit 36, with bit 35 = 1.
- R8: Push starts at entry 8. Register code 1100 is the stack pointer.
  - Word 8: rd1 1100, flag 001, op 011, opnd2 00, opnd1 01, wr 1100, kind 00, next 9.
  - Word 9: rd2 from the decoder, op 110, opnd2 01, opnd1 11, next 0.
- R9: Near call starts at entry 1.
  - Word 1: rd1 1100, flag 001, op 011, opnd2 00, opnd1 01, wr 1100, kind 01, next 2.
  - Word 2: op 110, opnd2 10, opnd1 11, next 3.
  - Word 3: op 101, opnd2 10, opnd1 00, next 0.
- R10: Near return starts at entry 4.
  - Word 4: input mode 110, op 101, opnd2 00, opnd1 11, kind 11, next 5.
  - Word 5: rd2 1100, op 011, opnd2 01, opnd1 00, wr 1100, next 0.
- R11: Store-string starts at entry 6. Register code 1000 is the accumulator and 1111 is the destination index.
  - Word 6: rd2 1000, op 000, opnd2 01, opnd1 11, next 7.
  - Word 7: rd1 1111, op 011, opnd2 00, opnd1 01, wr 1111, width forced to 1, next 0.
- R12: Field values for words 0 to 11. Input mode is 011 in words 1 to 9, except word 4 as given in R10. Every field not named in R8 to R11 is 0, and word 0 is entirely 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_valid | input | 1 | Decoder presents an entry microaddress |
| entry_addr | input | 5 | Entry microaddress from the decoder |
| dec_rd1_addr | input | 4 | Decoder's read-port-1 register address |
| dec_rd2_addr | input | 4 | Decoder's read-port-2 register address |
| dec_wide | input | 1 | Decoder's operand-width flag (1 = word) |
| step_en | input | 1 | Execution stage grants a step |
| mem_pending | input | 1 | Memory access still outstanding; hold the word |
| busy | output | 1 | A microprogram is active (microaddress nonzero) |
| uaddr | output | 5 | Current microaddress |
| rd1_addr | output | 4 | Resolved read-port-1 address |
| rd2_addr | output | 4 | Resolved read-port-2 address |
| wide | output | 1 | Resolved operand-width flag |
| in_mode | output | 3 | Memory input mode of the current word |
| flag_ctl | output | 3 | ALU flag control of the current word |
| alu_op | output | 3 | ALU operation of the current word |
| opnd2_sel | output | 2 | ALU operand-2 select |
| opnd1_sel | output | 2 | ALU operand-1 select |
| wr_addr | output | 4 | Result destination register |
| step_kind | output | 2 | Kind of the next execution step |

## Verification
Every field output comes straight out of the ROM through the current microaddress. A wrong microaddress is therefore visible on the very next sample after the edge that produced it: `uaddr`, `busy` and the whole field set disagree at once.

A keep or width-override bit that is decoded wrongly is more hidden. It only shows on `rd1_addr`, `rd2_addr` or `wide` during a word that sets the bit, or that should not. For that reason the decoder inputs are driven with distinctive values both inside and outside the push and store-string words. A hold fault under a pending memory access shows as a word skipped one cycle early.

// File: rtl/stack_useq_pkg.sv
package stack_useq_pkg;

    localparam int UA_W       = 5;
    localparam int NXT_W      = 6;
    localparam int RADDR_W    = 4;
    localparam int WORD_W     = 37;
    localparam int ROM_WORDS  = 10;
    localparam int N_RD_PORTS = 2;

    localparam logic [RADDR_W-1:0] RG_AX = 4'b1000;
    localparam logic [RADDR_W-1:0] RG_SP = 4'b1100;
    localparam logic [RADDR_W-1:0] RG_DI = 4'b1111;

    localparam logic [2:0] MODE_STD = 3'b011;
    localparam logic [2:0] MODE_POP = 3'b110;

    typedef struct packed {
        logic               wov_en;    // bit 36
        logic               wov_val;   // bit 35
        logic               keep2;     // bit 34
        logic               keep1;     // bit 33
        logic [RADDR_W-1:0] rd2;       // 32:29
        logic [2:0]         in_mode;   // 28:26
        logic [RADDR_W-1:0] rd1;       // 25:22
        logic [2:0]         flag_ctl;  // 21:19
        logic [2:0]         alu_op;    // 18:16
        logic [1:0]         opnd2;     // 15:14
        logic [1:0]         opnd1;     // 13:12
        logic [RADDR_W-1:0] wr;        // 11:8
        logic [1:0]         kind;      // 7:6
        logic [NXT_W-1:0]   nxt;       // 5:0
    } ctl_word_t;

    function automatic ctl_word_t rom_word(input int unsigned a);
        ctl_word_t w;
        w = '0;
        if (a >= 1 && a <= 9) w.in_mode = MODE_STD;
        case (a)
            1: begin  // call: stack pointer down by two
                w.rd1 = RG_SP; w.flag_ctl = 3'b001; w.alu_op = 3'b011;
                w.opnd1 = 2'b01; w.wr = RG_SP; w.kind = 2'b01; w.nxt = 6'd2;
            end
            2: begin  // call: program counter to stack
                w.alu_op = 3'b110; w.opnd2 = 2'b10; w.opnd1 = 2'b11; w.nxt = 6'd3;
            end
            3: begin  // call: add displacement
                w.alu_op = 3'b101; w.opnd2 = 2'b10;
            end
            4: begin  // return: stack top to program counter
                w.in_mode = MODE_POP; w.alu_op = 3'b101; w.opnd1 = 2'b11;
                w.kind = 2'b11; w.nxt = 6'd5;
            end
            5: begin  // return: stack pointer up by two
                w.rd2 = RG_SP; w.alu_op = 3'b011; w.opnd2 = 2'b01; w.wr = RG_SP;
            end
            6: begin  // store-string: accumulator to memory
                w.rd2 = RG_AX; w.opnd2 = 2'b01; w.opnd1 = 2'b11; w.nxt = 6'd7;
            end
            7: begin  // store-string: advance index at word width
                w.wov_en = 1'b1; w.wov_val = 1'b1; w.rd1 = RG_DI;
                w.alu_op = 3'b011; w.opnd1 = 2'b01; w.wr = RG_DI;
            end
            8: begin  // push: stack pointer down by two
                w.keep2 = 1'b1; w.rd1 = RG_SP; w.flag_ctl = 3'b001; w.alu_op = 3'b011;
                w.opnd1 = 2'b01; w.wr = RG_SP; w.nxt = 6'd9;
            end
            9: begin  // push: decoder-selected register to stack
                w.keep2 = 1'b1; w.alu_op = 3'b110; w.opnd2 = 2'b01; w.opnd1 = 2'b11;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/stack_useq_rom.sv
module stack_useq_rom
    import stack_useq_pkg::*;
#(
    parameter int DEPTH = ROM_WORDS
) (
    input  logic [UA_W-1:0] addr,
    output ctl_word_t       word
);

    ctl_word_t rom_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom_q[i] = rom_word(i);
    end

    always_comb begin
        if (int'(addr) < DEPTH) word = rom_q[addr];
        else                    word = '0;
    end

    always_comb begin
        AST_NEXT_IN_ROM: assert (int'(word.nxt) < DEPTH); // R5
        if (addr == '0) begin
            AST_IDLE_WORD_ZERO: assert (word == '0); // R12
        end
    end

endmodule

// File: rtl/stack_useq_ctr.sv
module stack_useq_ctr
    import stack_useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             entry_valid,
    input  logic [UA_W-1:0]  entry_addr,
    input  logic             step_en,
    input  logic             mem_pending,
    input  logic [NXT_W-1:0] next_field,
    output logic [UA_W-1:0]  uaddr,
    output logic             busy
);

    logic            idle;
    logic            advance;
    logic [UA_W-1:0] ua_d;

    assign idle    = (uaddr == '0);
    assign advance = !idle && step_en && !mem_pending;
    assign busy    = !idle;

    always_comb begin
        ua_d = uaddr;
        if (idle) begin
            if (entry_valid) ua_d = entry_addr;
        end else if (advance) begin
            ua_d = next_field[UA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) uaddr <= '0;
        else     uaddr <= ua_d;
    end

    always_comb begin
        AST_NEXT_FITS: assert (next_field[NXT_W-1:UA_W] == '0); // R4
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (uaddr == '0)); // R1

    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (idle && entry_valid) |=> (uaddr == $past(entry_addr))); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!idle && !advance) |=> $stable(uaddr)); // R3

    AST_ADVANCE_NEXT: assert property (@(posedge clk) disable iff (rst)
        advance |=> (uaddr == $past(next_field[UA_W-1:0]))); // R4

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (advance && next_field == '0) |=> !busy); // R5

endmodule

// File: rtl/stack_useq_resolve.sv
module stack_useq_resolve
    import stack_useq_pkg::*;
(
    input  logic [N_RD_PORTS-1:0]              keep,
    input  logic [N_RD_PORTS-1:0][RADDR_W-1:0] rom_rd,
    input  logic [N_RD_PORTS-1:0][RADDR_W-1:0] dec_rd,
    input  logic                               wov_en,
    input  logic                               wov_val,
    input  logic                               dec_wide,
    output logic [N_RD_PORTS-1:0][RADDR_W-1:0] rd,
    output logic                               wide
);

    for (genvar p = 0; p < N_RD_PORTS; p++) begin : g_port
        assign rd[p] = keep[p] ? dec_rd[p] : rom_rd[p];
    end

    assign wide = wov_en ? wov_val : dec_wide;

endmodule

// File: rtl/stack_useq.sv
module stack_useq
    import stack_useq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         entry_valid,
    input  logic [4:0]   entry_addr,
    input  logic [3:0]   dec_rd1_addr,
    input  logic [3:0]   dec_rd2_addr,
    input  logic         dec_wide,
    input  logic         step_en,
    input  logic         mem_pending,
    output logic         busy,
    output logic [4:0]   uaddr,
    output logic [3:0]   rd1_addr,
    output logic [3:0]   rd2_addr,
    output logic         wide,
    output logic [2:0]   in_mode,
    output logic [2:0]   flag_ctl,
    output logic [2:0]   alu_op,
    output logic [1:0]   opnd2_sel,
    output logic [1:0]   opnd1_sel,
    output logic [3:0]   wr_addr,
    output logic [1:0]   step_kind
);

    ctl_word_t                          word;
    logic [N_RD_PORTS-1:0][RADDR_W-1:0] rd_res;

    stack_useq_ctr u_ctr (
        .clk         (clk),
        .rst         (rst),
        .entry_valid (entry_valid),
        .entry_addr  (entry_addr),
        .step_en     (step_en),
        .mem_pending (mem_pending),
        .next_field  (word.nxt),
        .uaddr       (uaddr),
        .busy        (busy)
    );

    stack_useq_rom #(.DEPTH(ROM_WORDS)) u_rom (
        .addr (uaddr),
        .word (word)
    );

    stack_useq_resolve u_res (
        .keep     ({word.keep2, word.keep1}),
        .rom_rd   ({word.rd2, word.rd1}),
        .dec_rd   ({dec_rd2_addr, dec_rd1_addr}),
        .wov_en   (word.wov_en),
        .wov_val  (word.wov_val),
        .dec_wide (dec_wide),
        .rd       (rd_res),
        .wide     (wide)
    );

    assign rd1_addr  = rd_res[0];
    assign rd2_addr  = rd_res[1];
    assign in_mode   = word.in_mode;
    assign flag_ctl  = word.flag_ctl;
    assign alu_op    = word.alu_op;
    assign opnd2_sel = word.opnd2;
    assign opnd1_sel = word.opnd1;
    assign wr_addr   = word.wr;
    assign step_kind = word.kind;

endmodule

// File: tb/stack_useq_tb.sv
`timescale 1ns/1ps
module stack_useq_tb;

    typedef struct packed {
        logic [4:0] ua;
        logic       busy;
        logic [3:0] rd1;
        logic [3:0] rd2;
        logic       wide;
        logic [2:0] mode;
        logic [2:0] flag;
        logic [2:0] op;
        logic [1:0] o2;
        logic [1:0] o1;
        logic [3:0] wr;
        logic [1:0] kind;
    } obs_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic entry_valid = 1'b0;
    logic [4:0] entry_addr = '0;
    logic [3:0] dec_rd1_addr = '0;
    logic [3:0] dec_rd2_addr = '0;
    logic dec_wide = 1'b0;
    logic step_en = 1'b0;
    logic mem_pending = 1'b0;
    logic busy, wide;
    logic [4:0] uaddr;
    logic [3:0] rd1_addr, rd2_addr, wr_addr;
    logic [2:0] in_mode, flag_ctl, alu_op;
    logic [1:0] opnd2_sel, opnd1_sel, step_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [4:0] m_ua = '0;
    obs_t  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    stack_useq u_dut (
        .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_addr(entry_addr),
        .dec_rd1_addr(dec_rd1_addr), .dec_rd2_addr(dec_rd2_addr), .dec_wide(dec_wide),
        .step_en(step_en), .mem_pending(mem_pending), .busy(busy), .uaddr(uaddr),
        .rd1_addr(rd1_addr), .rd2_addr(rd2_addr), .wide(wide), .in_mode(in_mode),
        .flag_ctl(flag_ctl), .alu_op(alu_op), .opnd2_sel(opnd2_sel),
        .opnd1_sel(opnd1_sel), .wr_addr(wr_addr), .step_kind(step_kind)
    );

    function automatic logic [4:0] ref_next(input logic [4:0] ua);
        case (ua)
            5'd1: return 5'd2;
            5'd2: return 5'd3;
            5'd4: return 5'd5;
            5'd6: return 5'd7;
            5'd8: return 5'd9;
            default: return 5'd0;
        endcase
    endfunction

    function automatic obs_t ref_obs(input logic [4:0] ua, input logic [3:0] d2,
                                     input logic dw);
        obs_t o;
        o = '0;
        o.ua = ua;
        o.busy = (ua != 0);
        o.wide = dw;
        if (ua >= 1 && ua <= 9) o.mode = 3'b011;
        case (ua)
            5'd1: begin o.rd1 = 4'hC; o.flag = 3'b001; o.op = 3'b011; o.o1 = 2'b01;
                        o.wr = 4'hC; o.kind = 2'b01; end
            5'd2: begin o.op = 3'b110; o.o2 = 2'b10; o.o1 = 2'b11; end
            5'd3: begin o.op = 3'b101; o.o2 = 2'b10; end
            5'd4: begin o.mode = 3'b110; o.op = 3'b101; o.o1 = 2'b11; o.kind = 2'b11; end
            5'd5: begin o.rd2 = 4'hC; o.op = 3'b011; o.o2 = 2'b01; o.wr = 4'hC; end
            5'd6: begin o.rd2 = 4'h8; o.o2 = 2'b01; o.o1 = 2'b11; end
            5'd7: begin o.rd1 = 4'hF; o.op = 3'b011; o.o1 = 2'b01; o.wr = 4'hF;
                        o.wide = 1'b1; end
            5'd8: begin o.rd1 = 4'hC; o.rd2 = d2; o.flag = 3'b001; o.op = 3'b011;
                        o.o1 = 2'b01; o.wr = 4'hC; end
            5'd9: begin o.rd2 = d2; o.op = 3'b110; o.o2 = 2'b01; o.o1 = 2'b11; end
            default: ;
        endcase
        return o;
    endfunction

    task automatic drive(input logic r, input logic ev, input logic [4:0] ea,
                         input logic [3:0] d1, input logic [3:0] d2, input logic dw,
                         input logic se, input logic mp, input string tag);
        @(negedge clk);
        rst = r; entry_valid = ev; entry_addr = ea;
        dec_rd1_addr = d1; dec_rd2_addr = d2; dec_wide = dw;
        step_en = se; mem_pending = mp;
        if (r)                 m_ua = '0;
        else if (m_ua == 0)    begin if (ev) m_ua = ea; end
        else if (se && !mp)    m_ua = ref_next(m_ua);
        exp_q.push_back(ref_obs(m_ua, d2, dw));
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        obs_t e, a;
        string t;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{uaddr, busy, rd1_addr, rd2_addr, wide, in_mode, flag_ctl,
                      alu_op, opnd2_sel, opnd1_sel, wr_addr, step_kind};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R1 reset state");
        drive(1, 1, 5'd8, 0, 0, 0, 1, 0, "R1 reset dominates entry");
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R4 idle ignores step");
        drive(0, 1, 0, 0, 0, 0, 0, 0, "R2 zero entry stays idle");
        // push, register code 1011
        drive(0, 1, 5'd8, 4'h2, 4'hB, 0, 0, 0, "R2 R6 R8 push entry");
        drive(0, 0, 0, 4'h2, 4'hB, 0, 1, 1, "R4 hold on mem_pending");
        drive(0, 0, 0, 4'h2, 4'hB, 0, 0, 0, "R4 hold without step");
        drive(0, 0, 0, 4'h2, 4'hB, 0, 1, 0, "R8 push store word");
        drive(0, 1, 5'd1, 4'h2, 4'hB, 0, 0, 0, "R3 entry while busy ignored");
        drive(0, 1, 5'd4, 4'h2, 4'h6, 1, 0, 0, "R3 R6 second entry ignored");
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R5 push ends");
        // call
        drive(0, 1, 5'd1, 4'h3, 4'h5, 1, 0, 0, "R9 R6 call entry");
        drive(0, 0, 0, 4'h3, 4'h5, 1, 1, 0, "R9 call word 2");
        drive(0, 0, 0, 4'h3, 4'h5, 1, 1, 0, "R9 call word 3");
        drive(0, 0, 0, 4'h3, 4'h5, 1, 1, 0, "R5 R9 call ends");
        // return
        drive(0, 1, 5'd4, 0, 0, 1, 1, 0, "R10 return entry");
        drive(0, 0, 0, 0, 0, 1, 1, 1, "R4 R10 pending hold");
        drive(0, 0, 0, 0, 0, 1, 1, 0, "R10 return word 5");
        drive(0, 0, 0, 0, 0, 1, 1, 0, "R10 return ends");
        // store-string
        drive(0, 1, 5'd6, 0, 4'h9, 0, 0, 0, "R11 R7 store entry");
        drive(0, 0, 0, 0, 4'h9, 0, 1, 0, "R11 R7 width forced on word 7");
        drive(0, 0, 0, 0, 4'h9, 1, 0, 0, "R7 width forced with decoder word");
        drive(0, 0, 0, 0, 4'h9, 0, 1, 0, "R7 R5 width follows decoder when idle");
        // push with byte-class code to show keep passes any value
        drive(0, 1, 5'd8, 4'h7, 4'h9, 1, 1, 0, "R6 push keeps decoder address");
        drive(0, 0, 0, 4'h7, 4'h4, 1, 1, 0, "R6 push word 9 tracks decoder");
        drive(0, 0, 0, 4'h7, 4'h4, 1, 1, 0, "R5 push ends again");
        // unpopulated address
        drive(0, 1, 5'd20, 4'hA, 4'hA, 0, 0, 0, "R12 unpopulated word is zero");
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R5 unpopulated ends on first step");
        // reset in mid-sequence
        drive(0, 1, 5'd1, 0, 0, 0, 0, 0, "R9 call entry before reset");
        drive(1, 0, 0, 0, 0, 0, 1, 0, "R1 reset mid-sequence");
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R1 idle after reset");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule